// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. One 32-bit configuration word sets the clock. Its low field is the terminal count of a period counter. Its high field sets how long the clock stays high at the start of each period. A third field holds a divider value that software keeps with the timing. A single top bit picks what drives the counter: either every system clock cycle, or only the cycles on which an external tick input is high. Because the period and the high time are set separately, the duty cycle need not be 50%. The output runs from the system clock divided by 2 down to the system clock divided by 64.

The transfer engine holds the enable high for as long as it wants the clock. While enabled, the block drives a registered serial clock. It also sends the engine one-cycle pulses that coincide with each rising and each falling clock edge, which the engine uses to shift and to sample. Dropping the enable forces the clock low at once and clears the counter, so the next transfer begins with a whole period. A new configuration word is copied into the working counter only at the start of a period, so a write during a transfer never shortens or stretches the period in progress.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset the configuration word reads 0. A write with `cfg_we` high stores bit 31 (source select), bits 17:12 (divider), bits 11:6 (high count H) and bits 5:0 (low count L). `cfg_q` returns the written word masked with 0x8003FFFF on the cycle after the write.
- R2: With source select 0 and enable held high, the clock period is T+1 system cycles and the clock is high for the first Hc+1 cycles of each period. Here T is L, or 1 when L is 0, and Hc is H clamped to at most T-1. The divider field has no effect on the waveform.
- R3: `rise_o` is high for exactly the cycles in which `sck_o` has just gone from low to high. `fall_o` is high for exactly the cycles in which `sck_o` has just gone from high to low under enable. Neither pulse is high at any other time, and the two are never high together.
- R4: On the edge that first samples the enable high, the clock goes high and a period starts. On the edge that samples the enable low, `sck_o` goes low with no falling pulse and the counter clears. The clock then stays low until the enable returns, and the next period is full length.
- R5: A configuration write during a period leaves that period unchanged. The new L and H apply from the next period start.
- R6: With source select 1, the counter, including the start of the first period, advances only on cycles in which `alt_tick_i` is high. On all other cycles the clock and the pulses hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_q | output | 32 | Stored configuration word, unused bits zero |
| en_i | input | 1 | Clock request from the transfer engine |
| alt_tick_i | input | 1 | Count enable used when source select is 1 |
| sck_o | output | 1 | Serial clock |
| rise_o | output | 1 | One-cycle pulse on each rising serial clock edge |
| fall_o | output | 1 | One-cycle pulse on each falling serial clock edge |

## Verification
Every output is registered. The readback, the clock and both pulses change on the first rising edge that samples a write, an enable level or a tick, so each result is due one cycle after its stimulus. The bench drives inputs on falling edges and samples on the next falling edge. That puts the edge that consumes each stimulus between the drive and the sample. The expected waveform is computed from the number of counted cycles since the enable took effect, taken modulo the period. For the mid-period write, the bench switches to the new period at the cycle where the old period ends.

// File: rtl/spi_sck_gen.sv
`timescale 1ns/1ps
module spi_sck_gen #(
  parameter int CW      = 6,
  parameter int SRC_BIT = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_q,
  input  logic        en_i,
  input  logic        alt_tick_i,
  output logic        sck_o,
  output logic        rise_o,
  output logic        fall_o
);
  localparam int PAD = SRC_BIT - 3 * CW;

  logic          src_q;
  logic [CW-1:0] div_q, hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      div_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (cfg_we) begin
      src_q <= cfg_wdata[SRC_BIT];
      div_q <= cfg_wdata[3*CW-1:2*CW];
      hi_q  <= cfg_wdata[2*CW-1:CW];
      lo_q  <= cfg_wdata[CW-1:0];
    end
  end

  assign cfg_q = {src_q, {PAD{1'b0}}, div_q, hi_q, lo_q};

  logic [CW-1:0] term_w, hi_w;
  assign term_w = (lo_q == '0) ? CW'(1) : lo_q;
  assign hi_w   = (hi_q >= term_w) ? term_w - CW'(1) : hi_q;

  logic          run_q, a_src_q;
  logic [CW-1:0] cnt_q, a_term_q, a_hi_q;

  logic          tick, wrap, sck_nx;
  logic [CW-1:0] cnt_nx;
  assign tick   = (run_q ? a_src_q : src_q) ? alt_tick_i : 1'b1;
  assign wrap   = !run_q || (cnt_q == a_term_q);
  assign cnt_nx = cnt_q + CW'(1);
  assign sck_nx = (cnt_nx <= a_hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      a_src_q  <= 1'b0;
      cnt_q    <= '0;
      a_term_q <= CW'(1);
      a_hi_q   <= '0;
      sck_o    <= 1'b0;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sck_o  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (tick) begin
        if (wrap) begin
          run_q    <= 1'b1;
          cnt_q    <= '0;
          a_src_q  <= src_q;
          a_term_q <= term_w;
          a_hi_q   <= hi_w;
          sck_o    <= 1'b1;
          rise_o   <= 1'b1;
        end else begin
          cnt_q  <= cnt_nx;
          sck_o  <= sck_nx;
          fall_o <= sck_o && !sck_nx;
        end
      end
    end
  end
endmodule

module spi_sck_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic sck_o,
  input logic rise_o,
  input logic fall_o
);
  a_r3_rise_is_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (sck_o && !$past(sck_o)));
  a_r3_fall_is_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!sck_o && $past(sck_o)));
  a_r3_every_rise_pulsed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> rise_o);
  a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> (!sck_o && !rise_o && !fall_o));
endmodule

bind spi_sck_gen spi_sck_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i),
  .sck_o(sck_o), .rise_o(rise_o), .fall_o(fall_o)
);

// File: tb/spi_sck_gen_test.sv
`timescale 1ns/1ps
module spi_sck_gen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, en_i = 1'b0, alt_tick_i = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_q;
  logic sck_o, rise_o, fall_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_sck_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .en_i(en_i), .alt_tick_i(alt_tick_i),
    .sck_o(sck_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] word(int src, int dv, int h, int l);
    return (32'(src) << 31) | (32'(dv) << 12) | (32'(h) << 6) | 32'(l);
  endfunction

  task automatic cfg_write(logic [31:0] v);
    cfg_wdata = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_wave(string req, int t, int tt, int hh);
    int p = t % (tt + 1);
    chk(req, sck_o, p <= hh);
    chk("R3 rise", rise_o, p == 0);
    chk("R3 fall", fall_o, p == hh + 1);
  endtask

  task automatic run_fixed(int l, int h, int dv);
    int tt = (l == 0) ? 1 : l;
    int hh = (h >= tt) ? tt - 1 : h;
    cfg_write(word(0, dv, h, l));
    en_i = 1'b1;
    for (int t = 0; t < 3 * (tt + 1) + 1; t++) begin
      @(negedge clk);
      check_wave("R2", t, tt, hh);
    end
    en_i = 1'b0;
    @(negedge clk);
    chk("R4 sck off", sck_o, 0);
    chk("R4 no pulse", rise_o | fall_o, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", cfg_q, 0);
    chk("R1 reset sck", sck_o, 0);
    chk("R3 reset pulses", rise_o | fall_o, 0);

    cfg_write(32'hFFFF_FFFF);
    chk("R1 readback all ones", cfg_q, 32'h8003_FFFF);
    cfg_write(32'h1234_5678);
    chk("R1 readback pattern", cfg_q, 32'h1234_5678 & 32'h8003_FFFF);
    cfg_write(32'h7FFC_0000);
    chk("R1 readback unused", cfg_q, 0);

    for (int n = 1; n < 64; n++) run_fixed(n, (n + 1) / 2 - 1, n);
    run_fixed(0, 0, 0);
    run_fixed(4, 4, 4);
    run_fixed(4, 63, 2);
    run_fixed(7, 0, 7);
    run_fixed(7, 6, 7);
    run_fixed(3, 1, 45);
    run_fixed(3, 1, 0);

    // R5: write mid-period, old period completes first
    cfg_write(word(0, 5, 2, 5));
    en_i = 1'b1;
    for (int t = 0; t < 18; t++) begin
      @(negedge clk);
      if (t < 6) check_wave("R5 old period", t, 5, 2);
      else check_wave("R5 new period", t - 6, 3, 1);
      cfg_we = (t == 2);
      cfg_wdata = word(0, 3, 1, 3);
    end
    cfg_we = 1'b0;
    en_i = 1'b0;
    @(negedge clk);

    // R4: disable while high, then full restart
    cfg_write(word(0, 9, 6, 9));
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 high before drop", sck_o, 1);
    en_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 forced low", sck_o, 0);
      chk("R4 no fall pulse", rise_o | fall_o, 0);
    end
    en_i = 1'b1;
    for (int t = 0; t < 21; t++) begin
      @(negedge clk);
      check_wave("R4 full restart", t, 9, 6);
    end
    en_i = 1'b0;
    @(negedge clk);

    // R6: tick-gated source, one tick every third cycle
    cfg_write(word(1, 0, 1, 2));
    en_i = 1'b1;
    for (int j = 0; j < 40; j++) begin
      int k, p;
      alt_tick_i = (j % 3 == 0);
      @(negedge clk);
      k = j / 3 + 1;
      p = (k - 1) % 3;
      chk("R6 sck", sck_o, p <= 1);
      chk("R6 rise", rise_o, (j % 3 == 0) && p == 0);
      chk("R6 fall", fall_o, (j % 3 == 0) && p == 2);
    end
    alt_tick_i = 1'b0;
    en_i = 1'b0;
    @(negedge clk);
    chk("R4 off after R6", sck_o, 0);

    summary();
  end
endmodule